// File: doc/BRIEF.md
# Programmable Counter/Timer Channel

This block is a single down-counting channel programmed through a byte-wide write port. A written byte is read as a control word, a time constant or an interrupt vector, depending on its low bit and on whether a time constant is awaited. In timer mode the channel divides the system clock by a prescaler (16 or 256) and then by an 8-bit time constant. In counter mode it counts rising edges on a trigger input instead. Each time the count reaches zero it emits a one-clock pulse, reloads the time constant in the same cycle and, if enabled, raises an interrupt request that stays up until it is acknowledged.

Channels cascade by wiring one channel's zero-count pulse into the trigger of a second channel in counter mode. The overall period is then the product of both divisions.

The write decoder is a four-state machine. `ST_IDLE` is stopped, with no constant pending. `ST_ARM` is stopped, with a constant pending. `ST_RUN` is counting. `ST_RUN_ARM` is counting, with a replacement constant pending. A control word with the reset bit goes to `ST_ARM` if bit 2 is set and to `ST_IDLE` if it is clear. A control word without the reset bit sets or clears the pending flag and keeps running or stopped as before. A byte written in `ST_ARM` loads the counter and enters `ST_RUN`. A byte written in `ST_RUN_ARM` replaces the reload value and returns to `ST_RUN`. A byte with bit 0 = 0 written in `ST_IDLE` or `ST_RUN` updates the vector and leaves the state unchanged.

Top module: `tmr_chan`

## Requirements
- R1: After reset `zero_pulse` = 0, `irq` = 0 and `vec_out` = 0, and the channel stays stopped with no pulses until it is programmed.
- R2: When no time constant is pending, a byte with bit 0 = 1 is a control word and a byte with bit 0 = 0 is a vector. A vector byte sets `vec_out[7:3]` to its bits 7..3, and `vec_out[2:0]` stays 0. A control word leaves `vec_out` unchanged.
- R3: After a control word with bit 2 = 1, the next written byte of any value is taken as the time constant and does not change `vec_out`.
- R4: A control word with bit 1 = 1 (software reset) stops counting and clears a pending `irq`. The channel restarts only when a time constant is loaded.
- R5: Timer mode is selected by control bit 6 = 0. Let P be 256 when control bit 5 = 1 and 16 otherwise, and let N be the time constant, with 0 meaning 256. The first `zero_pulse` is visible P·N cycles after the clock edge that takes the constant, and further pulses follow every P·N cycles.
- R6: Counter mode is selected by control bit 6 = 1. The channel counts rising edges of `trig_in`. `zero_pulse` is visible in the cycle after the edge that samples the N-th rising edge, and again every N rising edges. A level held high counts once.
- R7: `zero_pulse` is high for exactly one cycle. The reload happens in that same cycle, so the period does not drift.
- R8: With control bit 7 = 1, `irq` rises together with `zero_pulse`. With bit 7 = 0, `irq` never rises.
- R9: `irq` stays high until `int_ack` is sampled high. A new zero count in the same cycle takes precedence over the acknowledge.
- R10: A new time constant written while running (a control word with bit 2 = 1 and bit 1 = 0, then the constant) leaves the current period unchanged and applies from the next reload.
- R11: With `trig_in` driven by another channel's `zero_pulse`, a counter-mode channel divides that pulse train by its N. Its pulse appears one cycle after the upstream pulse that completes the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte taken per cycle while high |
| wr_data | input | 8 | Written byte: control word, time constant or vector |
| trig_in | input | 1 | Edge input counted in counter mode |
| int_ack | input | 1 | Clears the pending interrupt request |
| zero_pulse | output | 1 | One-cycle pulse at each zero count |
| irq | output | 1 | Pending interrupt request |
| vec_out | output | 8 | Stored vector bits 7..3, low three bits zero |

## Verification
A time-constant write is taken at a clock edge E0, and the first timer pulse is expected exactly P·N negative edges after the one that follows E0. Later pulses are expected every P·N negative edges after that. In counter mode the pulse is expected at the first negative edge after the trigger goes high. `irq` is expected at the same negative edge as its pulse, and its clear is expected one negative edge after the acknowledge is raised. The bench drives every input and samples every output on the falling edge. It counts falling edges from a known reference, so each pulse must land on its exact cycle count rather than inside a window.

// File: rtl/tmr_chan_pkg.sv
`timescale 1ns/1ps
package tmr_chan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARM     = 2'd1,
        ST_RUN     = 2'd2,
        ST_RUN_ARM = 2'd3
    } chan_state_e;

    typedef struct packed {
        logic irq_en;
        logic cnt_mode;
        logic pre_hi;
    } chan_cfg_t;

    localparam int B_CTL  = 0;
    localparam int B_SRST = 1;
    localparam int B_TCF  = 2;
    localparam int B_PRE  = 5;
    localparam int B_MODE = 6;
    localparam int B_IEN  = 7;

endpackage

// File: rtl/tmr_chan_ctrl.sv
`timescale 1ns/1ps
module tmr_chan_ctrl
    import tmr_chan_pkg::*;
#(
    parameter int TC_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      wr_data,
    output logic            running_o,
    output chan_cfg_t       cfg_o,
    output logic [TC_W-1:0] tc_o,
    output logic            load_o,
    output logic [TC_W-1:0] load_val_o,
    output logic            srst_o,
    output logic [4:0]      vec_o
);

    chan_state_e state_q, state_d;
    chan_cfg_t   cfg_q;
    logic [TC_W-1:0] tc_q;
    logic [4:0]  vec_q;
    logic        tc_we, vec_we, cfg_we, load, srst;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and decode strobes
    always_comb begin
        state_d = state_q;
        tc_we   = 1'b0;
        vec_we  = 1'b0;
        cfg_we  = 1'b0;
        load    = 1'b0;
        srst    = 1'b0;
        if (wr_en) begin
            unique case (state_q)
                ST_ARM: begin
                    tc_we   = 1'b1;
                    load    = 1'b1;
                    state_d = ST_RUN;
                end
                ST_RUN_ARM: begin
                    tc_we   = 1'b1;
                    state_d = ST_RUN;
                end
                ST_IDLE, ST_RUN: begin
                    if (wr_data[B_CTL]) begin
                        cfg_we = 1'b1;
                        if (wr_data[B_SRST]) begin
                            srst    = 1'b1;
                            state_d = wr_data[B_TCF] ? ST_ARM : ST_IDLE;
                        end else if (state_q == ST_RUN) begin
                            state_d = wr_data[B_TCF] ? ST_RUN_ARM : ST_RUN;
                        end else begin
                            state_d = wr_data[B_TCF] ? ST_ARM : ST_IDLE;
                        end
                    end else begin
                        vec_we = 1'b1;
                    end
                end
            endcase
        end
    end

    // data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            tc_q  <= '0;
            vec_q <= '0;
        end else begin
            if (cfg_we) begin
                cfg_q.irq_en   <= wr_data[B_IEN];
                cfg_q.cnt_mode <= wr_data[B_MODE];
                cfg_q.pre_hi   <= wr_data[B_PRE];
            end
            if (tc_we)  tc_q  <= wr_data[TC_W-1:0];
            if (vec_we) vec_q <= wr_data[7:3];
        end
    end

    // outputs
    always_comb begin
        running_o  = (state_q == ST_RUN) || (state_q == ST_RUN_ARM);
        cfg_o      = cfg_q;
        tc_o       = tc_q;
        load_o     = load;
        load_val_o = wr_data[TC_W-1:0];
        srst_o     = srst;
        vec_o      = vec_q;
    end

    // R3
    tc_keeps_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (state_q == ST_ARM || state_q == ST_RUN_ARM)) |=> $stable(vec_q));

    // R5
    load_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (state_q == ST_RUN));

endmodule

// File: rtl/tmr_chan_step.sv
`timescale 1ns/1ps
module tmr_chan_step #(
    parameter int PRE_LO_LOG = 4,
    parameter int PRE_HI_LOG = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic cnt_mode,
    input  logic pre_hi,
    input  logic trig_in,
    output logic step
);

    localparam int PRE_W = PRE_HI_LOG;
    localparam logic [PRE_W-1:0] LO_LAST = PRE_W'((1 << PRE_LO_LOG) - 1);
    localparam logic [PRE_W-1:0] HI_LAST = '1;

    logic [PRE_W-1:0] pre_q;
    logic             trig_q;
    logic [PRE_W-1:0] last;
    logic             tick_t, tick_c;

    always_comb begin
        last   = pre_hi ? HI_LAST : LO_LAST;
        tick_t = run && !cnt_mode && (pre_q == last);
        tick_c = run && cnt_mode && trig_in && !trig_q;
        step   = tick_t || tick_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            trig_q <= 1'b0;
        end else begin
            trig_q <= trig_in;
            if (!run || cnt_mode) pre_q <= '0;
            else if (pre_q == last) pre_q <= '0;
            else pre_q <= pre_q + 1'b1;
        end
    end

    // R6
    step_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step);

endmodule

// File: rtl/tmr_chan_down.sv
`timescale 1ns/1ps
module tmr_chan_down #(
    parameter int TC_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            step,
    input  logic            load,
    input  logic [TC_W-1:0] load_val,
    input  logic [TC_W-1:0] reload_val,
    output logic            hit,
    output logic            zc
);

    localparam int CNT_W = TC_W + 1;
    localparam logic [CNT_W-1:0] FULL = {1'b1, {TC_W{1'b0}}};

    logic [CNT_W-1:0] cnt_q;

    function automatic logic [CNT_W-1:0] expand(input logic [TC_W-1:0] v);
        return (v == '0) ? FULL : {1'b0, v};
    endfunction

    always_comb hit = run && step && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            zc    <= 1'b0;
        end else begin
            zc <= hit;
            if (load)          cnt_q <= expand(load_val);
            else if (hit)      cnt_q <= expand(reload_val);
            else if (run && step) cnt_q <= cnt_q - 1'b1;
        end
    end

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zc |=> !zc);

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q != '0 && cnt_q <= FULL));

endmodule

// File: rtl/tmr_chan.sv
`timescale 1ns/1ps
module tmr_chan
    import tmr_chan_pkg::*;
#(
    parameter int TC_W       = 8,
    parameter int PRE_LO_LOG = 4,
    parameter int PRE_HI_LOG = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       trig_in,
    input  logic       int_ack,
    output logic       zero_pulse,
    output logic       irq,
    output logic [7:0] vec_out
);

    logic            running, load, srst, step, hit;
    chan_cfg_t       cfg;
    logic [TC_W-1:0] tc, load_val;
    logic [4:0]      vec;
    logic            irq_q;

    tmr_chan_ctrl #(.TC_W(TC_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .running_o(running), .cfg_o(cfg), .tc_o(tc), .load_o(load),
        .load_val_o(load_val), .srst_o(srst), .vec_o(vec)
    );

    tmr_chan_step #(.PRE_LO_LOG(PRE_LO_LOG), .PRE_HI_LOG(PRE_HI_LOG)) u_step (
        .clk(clk), .rst_n(rst_n), .run(running), .cnt_mode(cfg.cnt_mode),
        .pre_hi(cfg.pre_hi), .trig_in(trig_in), .step(step)
    );

    tmr_chan_down #(.TC_W(TC_W)) u_down (
        .clk(clk), .rst_n(rst_n), .run(running), .step(step), .load(load),
        .load_val(load_val), .reload_val(tc), .hit(hit), .zc(zero_pulse)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   irq_q <= 1'b0;
        else if (hit && cfg.irq_en)   irq_q <= 1'b1;
        else if (int_ack || srst)     irq_q <= 1'b0;
    end

    always_comb begin
        irq     = irq_q;
        vec_out = {vec, 3'b000};
    end

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !int_ack && !srst) |=> irq);

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> zero_pulse);

    // R4
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> !zero_pulse);

endmodule

// File: tb/test_tmr_chan.sv
`timescale 1ns/1ps
module test_tmr_chan;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_en_b = 1'b0;
    logic [7:0] wr_data = '0, wr_data_b = '0;
    logic trig = 1'b0, ack = 1'b0;
    logic zp, irq, zp_b, irq_b;
    logic [7:0] vec, vec_b;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    tmr_chan i_tmr_chan (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .trig_in(trig), .int_ack(ack), .zero_pulse(zp), .irq(irq), .vec_out(vec)
    );

    tmr_chan i_tmr_chan_b (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_b), .wr_data(wr_data_b),
        .trig_in(zp), .int_ack(1'b0), .zero_pulse(zp_b), .irq(irq_b), .vec_out(vec_b)
    );

    function automatic logic [7:0] ctl(input bit ien, input bit mode, input bit pre,
                                       input bit tcf, input bit srst);
        return {ien, mode, pre, 2'b00, tcf, srst, 1'b1};
    endfunction

    function automatic int exp_period(input bit pre, input int tc);
        return (pre ? 256 : 16) * ((tc == 0) ? 256 : tc);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_b(input logic [7:0] b);
        wr_en_b = 1'b1; wr_data_b = b;
        @(negedge clk);
        wr_en_b = 1'b0;
    endtask

    task automatic wait_zc(output int n);
        n = 0;
        while (!zp && n < 70000) begin @(negedge clk); n++; end
    endtask

    task automatic period(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!zp && n < 70000);
    endtask

    task automatic count_pulses(input int cyc, output int c);
        c = 0;
        repeat (cyc) begin @(negedge clk); if (zp) c++; end
    endtask

    task automatic trig_pulse(input int hi, output bit first, output bit extra);
        trig = 1'b1;
        @(negedge clk);
        first = zp; extra = 1'b0;
        repeat (hi - 1) begin @(negedge clk); if (zp) extra = 1'b1; end
        trig = 1'b0;
        @(negedge clk);
        if (zp) extra = 1'b1;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int n, c;
        bit f, x;
        void'($urandom(32'd11));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(zp == 0 && irq == 0, "R1 outputs", {zp, irq}, 0);
        chk(vec == 0, "R1 vector", vec, 0);
        count_pulses(200, c);
        chk(c == 0, "R1 stopped", c, 0);

        // R2 vector and control decode
        wr(8'hA8);
        chk(vec == 8'hA8, "R2 vector store", vec, 8'hA8);
        wr(8'h01);
        chk(vec == 8'hA8, "R2 control keeps vector", vec, 8'hA8);
        wr(8'h5E);
        chk(vec == 8'h58, "R2 vector bits 7..3", vec, 8'h58);

        // R3 constant follows, R5 timer first pulse and period
        wr(ctl(0, 0, 0, 1, 1));
        wr(8'h20);
        chk(vec == 8'h58, "R3 constant not vector", vec, 8'h58);
        wait_zc(n);
        chk(n == 512, "R5 first pulse", n, 512);
        @(negedge clk);
        chk(zp == 0, "R7 one cycle wide", zp, 0);
        n = 1;
        while (!zp && n < 70000) begin @(negedge clk); n++; end
        chk(n == 512, "R7 period no drift", n, 512);

        // R4 software reset stops
        wr(ctl(0, 0, 0, 0, 1));
        count_pulses(700, c);
        chk(c == 0, "R4 stopped after reset", c, 0);

        // R5 constant zero means 256
        wr(ctl(0, 0, 0, 1, 1));
        wr(8'h00);
        wait_zc(n);
        chk(n == 4096, "R5 constant zero", n, 4096);

        // R5 prescale 256, constant 255
        wr(ctl(0, 0, 1, 1, 1));
        wr(8'hFF);
        wait_zc(n);
        chk(n == 65280, "R5 prescale 256", n, 65280);

        // R5 random timer settings
        for (int i = 0; i < 5; i++) begin
            bit pre;
            int tc;
            pre = 1'($urandom % 2);
            tc  = pre ? int'($urandom % 8) + 1 : int'($urandom % 60) + 1;
            wr(ctl(0, 0, pre, 1, 1));
            wr(8'(tc));
            wait_zc(n);
            chk(n == exp_period(pre, tc), "R5 random first", n, exp_period(pre, tc));
            period(n);
            chk(n == exp_period(pre, tc), "R5 random period", n, exp_period(pre, tc));
        end

        // R10 constant change while running
        wr(ctl(0, 0, 0, 1, 1));
        wr(8'd4);
        wait_zc(n);
        wr(ctl(0, 0, 0, 1, 0));
        wr(8'd2);
        n = 2;
        while (!zp && n < 70000) begin @(negedge clk); n++; end
        chk(n == 64, "R10 current period kept", n, 64);
        period(n);
        chk(n == 32, "R10 new period", n, 32);

        // R8 and R9 interrupt
        wr(ctl(1, 0, 0, 1, 1));
        wr(8'd3);
        wait_zc(n);
        chk(irq == 1, "R8 irq with pulse", irq, 1);
        period(n);
        period(n);
        @(negedge clk);
        chk(irq == 1, "R9 irq held", irq, 1);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk(irq == 0, "R9 irq cleared by ack", irq, 0);
        period(n);
        chk(irq == 1, "R8 irq again", irq, 1);
        wr(ctl(1, 0, 0, 0, 1));
        chk(irq == 0, "R4 reset clears irq", irq, 0);
        wr(ctl(0, 0, 0, 1, 1));
        wr(8'd2);
        c = 0;
        for (int k = 0; k < 3; k++) begin
            period(n);
            if (irq) c++;
        end
        chk(c == 0, "R8 irq disabled", c, 0);

        // R6 counter mode
        wr(ctl(0, 1, 0, 1, 1));
        wr(8'd3);
        for (int k = 1; k <= 7; k++) begin
            trig_pulse((k == 2) ? 5 : 1, f, x);
            chk(f == (k % 3 == 0), "R6 edge count", f, (k % 3 == 0));
            chk(x == 0, "R6 level counts once", x, 0);
        end

        // R11 cascade
        wr(ctl(0, 0, 0, 0, 1));
        wr_b(ctl(0, 1, 0, 1, 1));
        wr_b(8'd3);
        wr(ctl(0, 0, 0, 1, 1));
        wr(8'd2);
        n = 0;
        while (!zp_b && n < 70000) begin @(negedge clk); n++; end
        chk(n == 97, "R11 cascade first", n, 97);
        n = 0;
        do begin @(negedge clk); n++; end while (!zp_b && n < 70000);
        chk(n == 96, "R11 cascade period", n, 96);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule